// File: doc/BRIEF.md
# Interrupt Acceptance Controller

This block sits beside a small microcontroller core. It decides at each instruction boundary whether a pending interrupt request is taken, and to which address the core is sent. It holds two 8-bit enable registers, written and read over a simple special-function-register bus. It receives latched request flags from ten sources: two timers, one serial channel and seven external pins. It also receives a 2-bit priority level per source and three per-instruction status signals from the core.

When it accepts a request, the block raises a one-cycle forced-call request carrying the vector address. It marks the level being serviced in its own in-service record. A return-from-interrupt instruction releases the highest serviced level.

A boundary whose instruction was a return-from-interrupt, or a write to any enable or priority register, takes nothing. At least one more instruction then runs before a request can be taken.

The control flow is a three-state machine:
- **RUN**: normal execution.
- **BLOCK**: the last boundary was a held-off one.
- **CALL**: the forced-call request is being issued.

Its transitions are:
- **take**: RUN or BLOCK to CALL, on a boundary that accepts a request.
- **hold**: RUN or BLOCK to BLOCK, on a return or control-write boundary.
- **resume**: BLOCK to RUN, on a plain boundary with no winner.
- **done**: CALL to RUN, always after one cycle.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset both enable registers read 0x00, `call_req` is low and no priority level is in service.
- R2: A bus write at address 0xA8 (register A) or 0xB8 (register B) stores all 8 data bits. `sfr_rdata` returns the stored byte for those addresses and 0x00 for any other address.
- R3: Register A bit 7 is the master enable. While it is 0 no request is accepted, whatever the other bits hold.
- R4: Register A bits 0..4 enable sources 0..4 (ext0, timer0, ext1, timer1, serial0). Register B bits 1..5 enable sources 5..9 (ext2..ext6). Register A bits 5 and 6 and register B bits 0, 6 and 7 have no effect on acceptance.
- R5: A request is accepted only on a cycle with `insn_done` high. `call_req` is then high for exactly the one cycle after that clock edge. `insn_done` is ignored while `call_req` is high.
- R6: The vector for source i is 0x0003 + 8*i (0x03, 0x0B, 0x13 ... 0x4B).
- R7: Among enabled pending sources, the highest level (0..3, from `irq_lvl[2i+1:2i]`) wins. On equal levels, the lowest source index wins.
- R8: A winner is accepted only if its level is strictly above the highest level in service. A higher level nests over a lower one.
- R9: Accepting a request marks its level in service. A boundary with `insn_is_reti` high clears the highest in-service level.
- R10: A boundary with `insn_is_reti` or `insn_wr_ctl` high accepts nothing. The next plain boundary may accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| irq_req | input | 10 | Latched request flags, one per source |
| irq_lvl | input | 20 | 2-bit priority level per source |
| insn_done | input | 1 | Current instruction completes this cycle |
| insn_is_reti | input | 1 | Completing instruction is a return-from-interrupt |
| insn_wr_ctl | input | 1 | Completing instruction wrote an enable or priority register |
| call_req | output | 1 | Forced-call request, one cycle |
| call_vec | output | 16 | Vector address of the accepted source |

## Verification
The accept decision is taken at the clock edge where `insn_done` is high. `call_req` and `call_vec` are therefore due one cycle later, and the scoreboard monitor samples them at the falling edge that follows that boundary edge. On each accepted call the monitor also samples the next falling edge, to confirm the pulse lasted one cycle. Register read data is combinational, so it is checked half a cycle after the address is applied. Every boundary is followed by an idle cycle, so the CALL state never overlaps the next boundary.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    localparam int unsigned NUM_SRC = 10;
    localparam int unsigned LVL_W   = 2;
    localparam int unsigned NUM_LVL = 1 << LVL_W;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BLOCK = 2'd1,
        ST_CALL  = 2'd2
    } acc_state_t;
endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_accept_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter logic [7:0]  A_ADDR  = 8'hA8,
    parameter logic [7:0]  B_ADDR  = 8'hB8,
    parameter int unsigned A_CNT   = 5,
    parameter int unsigned A_FIRST = 0,
    parameter int unsigned B_FIRST = 1,
    parameter int unsigned GLB_BIT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sfr_wr,
    input  logic [ADDR_W-1:0]   sfr_addr,
    input  logic [REG_W-1:0]    sfr_wdata,
    output logic [REG_W-1:0]    sfr_rdata,
    output logic                glb_en,
    output logic [NUM_SRC-1:0]  src_en
);
    localparam int unsigned B_CNT = NUM_SRC - A_CNT;

    logic [REG_W-1:0] reg_a_q;
    logic [REG_W-1:0] reg_b_q;

    // Register storage: every bit is kept, including the ones with no interrupt role.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a_q <= '0;
            reg_b_q <= '0;
        end else if (sfr_wr) begin
            if (sfr_addr == A_ADDR[ADDR_W-1:0]) reg_a_q <= sfr_wdata;
            if (sfr_addr == B_ADDR[ADDR_W-1:0]) reg_b_q <= sfr_wdata;
        end
    end

    always_comb begin
        if (sfr_addr == A_ADDR[ADDR_W-1:0])      sfr_rdata = reg_a_q;
        else if (sfr_addr == B_ADDR[ADDR_W-1:0]) sfr_rdata = reg_b_q;
        else                                     sfr_rdata = '0;
    end

    assign glb_en = reg_a_q[GLB_BIT];

    // Map register bits onto source enables, gated by the master bit.
    for (genvar i = 0; i < A_CNT; i++) begin : g_a_map
        assign src_en[i] = reg_a_q[A_FIRST + i] & glb_en;
    end
    for (genvar j = 0; j < B_CNT; j++) begin : g_b_map
        assign src_en[A_CNT + j] = reg_b_q[B_FIRST + j] & glb_en;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_accept_pkg::*;
(
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC-1:0]       en,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);
    logic [NUM_SRC-1:0] elig;
    logic [LVL_W-1:0]   lvl [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign elig[i] = req[i] & en[i];
        assign lvl[i]  = lvl_flat[i*LVL_W +: LVL_W];
    end

    // Scan upward; replace only on a strictly higher level so ties keep the lower index.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_valid || lvl[i] > win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track
    import irq_accept_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [LVL_W-1:0]   set_lvl,
    input  logic               clr_top,
    output logic [NUM_LVL-1:0] in_service,
    output logic               act_valid,
    output logic [LVL_W-1:0]   act_lvl
);
    logic [NUM_LVL-1:0] svc_q;

    always_comb begin
        act_valid = 1'b0;
        act_lvl   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (svc_q[l]) begin
                act_valid = 1'b1;
                act_lvl   = LVL_W'(l);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else if (set_en) begin
            svc_q <= svc_q | (NUM_LVL'(1) << set_lvl);
        end else if (clr_top && act_valid) begin
            svc_q <= svc_q & ~(NUM_LVL'(1) << act_lvl);
        end
    end

    assign in_service = svc_q;
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sfr_wr,
    input  logic [7:0]               sfr_addr,
    input  logic [7:0]               sfr_wdata,
    output logic [7:0]               sfr_rdata,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic                     insn_done,
    input  logic                     insn_is_reti,
    input  logic                     insn_wr_ctl,
    output logic                     call_req,
    output logic [VEC_W-1:0]         call_vec
);
    acc_state_t         state_q, state_d;
    logic               glb_en;
    logic [NUM_SRC-1:0] src_en;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic [NUM_LVL-1:0] in_service;
    logic               act_valid;
    logic [LVL_W-1:0]   act_lvl;
    logic               boundary, held_off, lvl_ok, accept, reti_bnd;
    logic [VEC_W-1:0]   vec_q;

    irq_enable_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_wr    (sfr_wr),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .glb_en    (glb_en),
        .src_en    (src_en)
    );

    irq_arbiter u_arb (
        .req       (irq_req),
        .en        (src_en),
        .lvl_flat  (irq_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    // A boundary counts only outside the call cycle.
    assign boundary = insn_done && (state_q != ST_CALL);
    assign held_off = insn_is_reti || insn_wr_ctl;
    assign lvl_ok   = !act_valid || (win_lvl > act_lvl);
    assign accept   = boundary && !held_off && win_valid && lvl_ok;
    assign reti_bnd = boundary && insn_is_reti;

    irq_service_track u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (accept),
        .set_lvl    (win_lvl),
        .clr_top    (reti_bnd),
        .in_service (in_service),
        .act_valid  (act_valid),
        .act_lvl    (act_lvl)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic: take, hold, resume, done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_BLOCK: begin
                if (boundary) begin
                    if (held_off)    state_d = ST_BLOCK;
                    else if (accept) state_d = ST_CALL;
                    else             state_d = ST_RUN;
                end
            end
            ST_CALL: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Vector captured on the accepting edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vec_q <= '0;
        else if (accept) vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);
    end

    // Outputs
    always_comb begin
        call_req = (state_q == ST_CALL);
        call_vec = vec_q;
    end
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker
    import irq_accept_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               insn_done,
    input logic               insn_is_reti,
    input logic               insn_wr_ctl,
    input logic               glb_en,
    input logic [NUM_LVL-1:0] in_service,
    input logic               call_req,
    input logic [15:0]        call_vec
);
    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !call_req);

    assert_call_after_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(insn_done));

    assert_no_call_after_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> !$past(insn_is_reti) && !$past(insn_wr_ctl));

    assert_master_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(glb_en));

    assert_vector_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec[2:0] == 3'b011) && (call_vec <= 16'h004B));

    assert_level_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (in_service != '0));
endmodule

bind irq_accept_ctrl irq_accept_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_done    (insn_done),
    .insn_is_reti (insn_is_reti),
    .insn_wr_ctl  (insn_wr_ctl),
    .glb_en       (glb_en),
    .in_service   (in_service),
    .call_req     (call_req),
    .call_vec     (call_vec)
);

// File: tb/irq_accept_ctrl_bench.sv
module irq_accept_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [9:0]  irq_req = '0;
    logic [19:0] irq_lvl = '0;
    logic        insn_done = 1'b0;
    logic        insn_is_reti = 1'b0;
    logic        insn_wr_ctl = 1'b0;
    logic        call_req;
    logic [15:0] call_vec;

    int checks = 0;
    int fails  = 0;

    bit          exp_q[$];
    logic [15:0] vec_q[$];
    string       tag_q[$];

    localparam logic [7:0] ADDR_A = 8'hA8;
    localparam logic [7:0] ADDR_B = 8'hB8;

    always #2.5 clk = ~clk;

    irq_accept_ctrl u_irq_accept_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sfr_wr       (sfr_wr),
        .sfr_addr     (sfr_addr),
        .sfr_wdata    (sfr_wdata),
        .sfr_rdata    (sfr_rdata),
        .irq_req      (irq_req),
        .irq_lvl      (irq_lvl),
        .insn_done    (insn_done),
        .insn_is_reti (insn_is_reti),
        .insn_wr_ctl  (insn_wr_ctl),
        .call_req     (call_req),
        .call_vec     (call_vec)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input int i);
        return 16'(3 + 8 * i);
    endfunction

    task automatic set_lvl(input int i, input logic [1:0] l);
        irq_lvl[2*i +: 2] = l;
    endtask

    task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        sfr_addr = a;
        #1;
        check(sfr_rdata === e, tag, sfr_rdata, e);
    endtask

    // Driver: queue the expected outcome, then present one instruction boundary.
    task automatic bnd(input bit reti, input bit wr, input bit e, input logic [15:0] v,
                       input string tag);
        exp_q.push_back(e); vec_q.push_back(v); tag_q.push_back(tag);
        @(negedge clk);
        insn_done = 1'b1; insn_is_reti = reti; insn_wr_ctl = wr;
        @(negedge clk);
        insn_done = 1'b0; insn_is_reti = 1'b0; insn_wr_ctl = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: result is due at the falling edge after the boundary edge.
    initial begin
        forever begin
            @(posedge clk);
            if (insn_done && rst_n) begin
                bit e; logic [15:0] v; string t;
                @(negedge clk);
                e = exp_q.pop_front(); v = vec_q.pop_front(); t = tag_q.pop_front();
                check(call_req === e, {t, " call_req"}, call_req, e);
                if (e) begin
                    check(call_vec === v, {t, " call_vec"}, call_vec, v);
                    @(negedge clk);
                    check(call_req === 1'b0, "R5 pulse width", call_req, 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(call_req === 1'b0, "R1 call_req in reset", call_req, 0);
        rst_n = 1'b1;
        rd_check(ADDR_A, 8'h00, "R1 reg A reset");
        rd_check(ADDR_B, 8'h00, "R1 reg B reset");
        irq_req = 10'h3FF;
        bnd(0, 0, 0, 0, "R1 nothing enabled");

        // R2 read-back of all bits, unmapped address
        wr_sfr(ADDR_B, 8'hFF);
        rd_check(ADDR_B, 8'hFF, "R2 reg B all bits");
        rd_check(8'h55, 8'h00, "R2 unmapped address");
        wr_sfr(ADDR_B, 8'h00);

        // R3 master enable off blocks all
        wr_sfr(ADDR_A, 8'h7F);
        rd_check(ADDR_A, 8'h7F, "R2 reg A value");
        bnd(0, 1, 0, 0, "R10 control write boundary");
        bnd(0, 0, 0, 0, "R3 master enable clear");

        // R4 no-effect bits with master on
        wr_sfr(ADDR_A, 8'hE0);
        wr_sfr(ADDR_B, 8'hC1);
        bnd(0, 1, 0, 0, "R10 control write boundary");
        bnd(0, 0, 0, 0, "R4 non-enable bits only");

        // R4/R6/R10: each source alone enabled, all requests pending
        for (int i = 0; i < 10; i++) begin
            if (i < 5) begin
                wr_sfr(ADDR_A, 8'hE0 | 8'(1 << i));
                wr_sfr(ADDR_B, 8'hC1);
            end else begin
                wr_sfr(ADDR_A, 8'hE0);
                wr_sfr(ADDR_B, 8'hC1 | 8'(1 << (i - 4)));
            end
            bnd(0, 1, 0, 0, "R10 write boundary held");
            bnd(0, 0, 1, vec_of(i), "R4 R6 single source vector");
            bnd(1, 0, 0, 0, "R10 return boundary held");
        end

        // Enable all sources for the rest.
        wr_sfr(ADDR_A, 8'h9F);
        wr_sfr(ADDR_B, 8'h3E);
        bnd(0, 1, 0, 0, "R10 write boundary");

        // R7 tie -> lowest index
        irq_req = '0; irq_req[4] = 1'b1; irq_req[6] = 1'b1;
        set_lvl(4, 2'd1); set_lvl(6, 2'd1);
        bnd(0, 0, 1, vec_of(4), "R7 tie lowest index");
        irq_req[4] = 1'b0;
        // R8 same level in service blocks source 6
        bnd(0, 0, 0, 0, "R8 equal level blocked");
        // R9 return clears, R10 holds that boundary, then 6 taken
        bnd(1, 0, 0, 0, "R10 return boundary");
        bnd(0, 0, 1, vec_of(6), "R9 after release");
        irq_req = '0;
        bnd(1, 0, 0, 0, "R9 release level 1");

        // R7 higher level beats lower index
        irq_lvl = '0;
        irq_req[0] = 1'b1; irq_req[9] = 1'b1; set_lvl(9, 2'd2);
        bnd(0, 0, 1, vec_of(9), "R7 highest level wins");
        irq_req[9] = 1'b0;
        // R8 nesting: level 3 over level 2
        irq_req[3] = 1'b1; set_lvl(3, 2'd3);
        bnd(0, 0, 1, vec_of(3), "R8 higher level nests");
        irq_req[3] = 1'b0;
        irq_req[2] = 1'b1; set_lvl(2, 2'd2);
        bnd(0, 0, 0, 0, "R8 level 2 blocked under 3");
        bnd(1, 0, 0, 0, "R9 release level 3");
        bnd(0, 0, 0, 0, "R8 level 2 still in service");
        bnd(1, 0, 0, 0, "R9 release level 2");
        bnd(0, 0, 1, vec_of(2), "R9 level 2 taken after release");
        irq_req[2] = 1'b0;
        bnd(1, 0, 0, 0, "R9 release");
        // consecutive held boundaries, then source 0 (level 0)
        bnd(0, 1, 0, 0, "R10 write boundary");
        bnd(1, 0, 0, 0, "R10 return boundary");
        bnd(0, 0, 1, vec_of(0), "R10 accept after held");
        irq_req = '0;
        bnd(1, 0, 0, 0, "R9 release");

        // R5 no acceptance without a boundary
        irq_req[1] = 1'b1;
        repeat (3) @(negedge clk);
        check(call_req === 1'b0, "R5 no call without boundary", call_req, 0);
        bnd(0, 0, 1, vec_of(1), "R5 call at boundary");

        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule